// File: doc/BRIEF.md
# Interlock Event History Recorder

This block sits beside an interlock controller and watches the controller's user permit inputs and its beam permit outputs. It keeps a record of every change to those signals. In each clock cycle where any watched signal differs from its value in the previous cycle, the block writes one record into a circular memory. A record holds the current microsecond time, a snapshot of all inputs and outputs, and a mask of the inputs that changed.

Microsecond time comes from a free-running counter that a prescaler advances once per microsecond of system clock. Supervision logic can load the counter with absolute time, and the loaded value takes effect on the following microsecond tick. The block only observes the permit path and never drives it.

Supervision logic drains the records oldest first through a show-ahead read port. When the memory is full, new records replace the oldest unread ones, and a sticky flag reports that records were lost. When a beam permit output falls, the block writes a programmable number of further records and then stops writing. The history around the first loss of permit is therefore kept until supervision re-arms the block.

Top module: `interlock_history`

## Requirements
- R1: From the second clock after reset, a change on any permit input writes one record. The record holds the new input vector and a changed mask with a 1 at each bit position that toggled.
- R2: A change on any beam permit output writes one record holding the new output vector. Its changed mask is zero when no input toggled.
- R3: Changes on several signals in the same cycle produce exactly one record, with every toggled input bit set in the mask.
- R4: The time counter starts at 0 after reset and advances by one every PRESCALE clocks. A record carries the counter value from the cycle in which the change is sampled.
- R5: A value presented with a time_load pulse replaces the counter on the first tick after the pulse, and counting continues from that value.
- R6: Records are read oldest first. rd_valid is high when rd_count is non-zero, and each rd_pop while valid removes one record.
- R7: A record written while DEPTH records are unread discards the oldest one, leaves rd_count at DEPTH and sets the overflow flag. The flag stays set until a rearm.
- R8: The first fall of any beam permit output bit is recorded. Exactly freeze_post more records are then written, after which frozen goes high and no record is written. Further falls while counting do not restart the count.
- R9: A rearm pulse clears frozen and the overflow flag, and logging resumes at the next change.
- R10: After reset, rd_count is 0, rd_valid is low, overflow is low and frozen is low.
- R11: No record is written in the first cycle after reset or in any cycle without a change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| permit_in | input | N_IN | User permit inputs being watched |
| beam_out | input | N_OUT | Beam permit outputs being watched |
| time_load | input | 1 | Pulse: load time_value at the next tick |
| time_value | input | TS_W | Absolute time in microseconds |
| rearm | input | 1 | Pulse: leave frozen state, clear overflow |
| freeze_post | input | FRZ_W | Records allowed after the first permit fall |
| rd_pop | input | 1 | Remove the oldest record |
| rd_valid | output | 1 | A record is available |
| rd_time | output | TS_W | Time tag of the oldest record |
| rd_inputs | output | N_IN | Input snapshot of the oldest record |
| rd_outputs | output | N_OUT | Output snapshot of the oldest record |
| rd_changed | output | N_IN | Changed-input mask of the oldest record |
| rd_count | output | log2(DEPTH+1) | Number of unread records |
| overflow | output | 1 | Sticky: unread records were overwritten |
| frozen | output | 1 | Recording stopped after a permit loss |

## Verification
The bench builds the block with DEPTH of 8 and PRESCALE of 4 and keeps the default port widths. The shallow memory lets a burst of ten changes wrap the pointers and set the overflow flag within a few cycles. The short prescaler makes many ticks pass between events, so a wrong time tag or a late time load shows up as a mismatched record. A small freeze_post value covers the freeze window, including a second permit fall inside that window.

// File: rtl/interlock_history.sv
module interlock_history #(
  parameter int N_IN     = 15,
  parameter int N_OUT    = 2,
  parameter int TS_W     = 64,
  parameter int DEPTH    = 256,
  parameter int PRESCALE = 100,
  parameter int FRZ_W    = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_IN-1:0]                permit_in,
  input  logic [N_OUT-1:0]               beam_out,
  input  logic                           time_load,
  input  logic [TS_W-1:0]                time_value,
  input  logic                           rearm,
  input  logic [FRZ_W-1:0]               freeze_post,
  input  logic                           rd_pop,
  output logic                           rd_valid,
  output logic [TS_W-1:0]                rd_time,
  output logic [N_IN-1:0]                rd_inputs,
  output logic [N_OUT-1:0]               rd_outputs,
  output logic [N_IN-1:0]                rd_changed,
  output logic [$clog2(DEPTH+1)-1:0]     rd_count,
  output logic                           overflow,
  output logic                           frozen
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int PW    = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int ENT_W = TS_W + N_IN + N_OUT + N_IN;

  logic [PW-1:0]    pcnt;
  logic [TS_W-1:0]  ts, pend_val;
  logic             pend;
  logic             primed;
  logic [N_IN-1:0]  prev_in;
  logic [N_OUT-1:0] prev_out;
  logic             armed;
  logic [FRZ_W-1:0] left;
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic [ENT_W-1:0] mem [DEPTH];

  wire              tick    = (pcnt == PW'(PRESCALE - 1));
  wire [N_IN-1:0]   chg_in  = primed ? (permit_in ^ prev_in) : '0;
  wire [N_OUT-1:0]  chg_out = primed ? (beam_out ^ prev_out) : '0;
  wire              evt     = (|chg_in) | (|chg_out);
  wire              fall    = primed & (|(prev_out & ~beam_out));
  wire              full    = (count == CW'(DEPTH));
  wire              pop     = rd_pop & (count != '0);
  wire              wr      = evt & ~frozen;
  wire              drop    = wr & full & ~pop;

  assign frozen   = armed & (left == '0);
  assign rd_valid = (count != '0);
  assign rd_count = count;
  assign {rd_time, rd_inputs, rd_outputs, rd_changed} = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt <= '0; ts <= '0; pend <= 1'b0; pend_val <= '0;
    end else begin
      pcnt <= tick ? '0 : pcnt + 1'b1;
      if (tick) ts <= pend ? pend_val : ts + 1'b1;
      if (time_load) begin
        pend     <= 1'b1;
        pend_val <= time_value;
      end else if (tick) begin
        pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed <= 1'b0; prev_in <= '0; prev_out <= '0;
    end else begin
      primed   <= 1'b1;
      prev_in  <= permit_in;
      prev_out <= beam_out;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0; left <= '0;
    end else if (rearm) begin
      armed <= 1'b0;
    end else if (fall && !armed) begin
      armed <= 1'b1;
      left  <= freeze_post;
    end else if (wr && armed && left != '0) begin
      left <= left - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr) mem[wr_ptr] <= {ts, permit_in, beam_out, chg_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; count <= '0; overflow <= 1'b0;
    end else begin
      if (wr) wr_ptr <= wr_ptr + 1'b1;
      if (pop || drop) rd_ptr <= rd_ptr + 1'b1;
      if (wr && !pop && !full) count <= count + 1'b1;
      else if (pop && !wr) count <= count - 1'b1;
      if (rearm) overflow <= 1'b0;
      if (drop) overflow <= 1'b1;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R6
  AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && rd_valid && !evt) |=> rd_count == $past(rd_count) - 1'b1); // R6
  AST_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rd_count <= $past(rd_count) + 1'b1); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !rearm) |=> overflow); // R7
  AST_FROZEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !rd_pop) |=> $stable(rd_count)); // R8
  AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ts)); // R4
  AST_PRIME_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |=> rd_count == '0); // R11
endmodule

// File: tb/test_interlock_history.sv
module test_interlock_history;
  localparam int N_IN = 15, N_OUT = 2, TS_W = 64, D = 8, P = 4, FW = 8;
  localparam int EW = TS_W + N_IN + N_OUT + N_IN;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N_IN-1:0]  permit_in = '1;
  logic [N_OUT-1:0] beam_out  = '1;
  logic time_load = 1'b0, rearm = 1'b0, rd_pop = 1'b0;
  logic [TS_W-1:0] time_value = '0;
  logic [FW-1:0] freeze_post = 8'd200;
  logic rd_valid, overflow, frozen;
  logic [TS_W-1:0] rd_time;
  logic [N_IN-1:0] rd_inputs, rd_changed;
  logic [N_OUT-1:0] rd_outputs;
  logic [$clog2(D+1)-1:0] rd_count;

  interlock_history #(.N_IN(N_IN), .N_OUT(N_OUT), .TS_W(TS_W), .DEPTH(D),
                      .PRESCALE(P), .FRZ_W(FW)) i_interlock_history (
    .clk, .rst_n, .permit_in, .beam_out, .time_load, .time_value, .rearm,
    .freeze_post, .rd_pop, .rd_valid, .rd_time, .rd_inputs, .rd_outputs,
    .rd_changed, .rd_count, .overflow, .frozen);

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [EW-1:0] q[$];
  bit exp_ovf = 0, b_armed = 0;
  int b_left = 0;

  // Reference microsecond clock from R4/R5
  int unsigned mcnt;
  logic [TS_W-1:0] mts, mval;
  bit mpend;
  always @(posedge clk) begin
    if (!rst_n) begin
      mcnt <= 0; mts <= '0; mpend <= 0; mval <= '0;
    end else begin
      if (mcnt == P - 1) begin
        mcnt <= 0;
        mts  <= mpend ? mval : mts + 1;
      end else mcnt <= mcnt + 1;
      if (time_load) begin mpend <= 1; mval <= time_value; end
      else if (mcnt == P - 1) mpend <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Driver: applies a change and pushes the expected record
  task automatic apply(input logic [N_IN-1:0] ni, input logic [N_OUT-1:0] no);
    logic [N_IN-1:0] chg;
    bit fell, logged;
    @(negedge clk);
    chg    = ni ^ permit_in;
    fell   = |(beam_out & ~no);
    logged = ((chg != '0) || (no != beam_out)) && !(b_armed && b_left == 0);
    if (logged) begin
      q.push_back({mts, ni, no, chg});
      if (q.size() > D) begin void'(q.pop_front()); exp_ovf = 1; end
      if (b_armed && b_left > 0) b_left--;
    end
    if (fell && !b_armed && ((chg != '0) || (no != beam_out))) begin
      b_armed = 1; b_left = freeze_post;
    end
    permit_in = ni;
    beam_out  = no;
  endtask

  // Monitor: pops the design's records and compares with the queue
  task automatic drain(input string req);
    logic [EW-1:0] e;
    @(negedge clk);
    while (rd_valid) begin
      e = (q.size() > 0) ? q.pop_front() : '0;
      chk({rd_time, rd_inputs, rd_outputs, rd_changed} === e, req,
          {rd_time, rd_inputs, rd_outputs, rd_changed}, e);
      rd_pop = 1;
      @(negedge clk);
      rd_pop = 0;
    end
    chk(q.size() == 0, {req, " queue empty"}, q.size(), 0);
  endtask

  task automatic do_rearm();
    @(negedge clk); rearm = 1;
    @(negedge clk); rearm = 0;
    b_armed = 0; exp_ovf = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(rd_count == 0 && !rd_valid, "R10 count/valid", {rd_count, rd_valid}, 0);
    chk(!overflow && !frozen, "R10 flags", {overflow, frozen}, 0);
    // R11 quiet after reset and without changes
    idle(5);
    chk(rd_count == 0, "R11 no change no record", rd_count, 0);

    // R1 single input drop
    apply(15'h7FF7, 2'b11);
    idle(3);
    chk(rd_count == 1, "R1 one record", rd_count, 1);
    drain("R1 input record");

    // R2 output change, no input change
    apply(15'h7FF7, 2'b01);
    drain("R2 output record");
    do_rearm();

    // R3 simultaneous changes
    apply(15'h7AF6, 2'b11);
    @(negedge clk);
    chk(rd_count == 1, "R3 single record", rd_count, 1);
    drain("R3 combined mask");

    // R4 time tags across several ticks
    idle(9);  apply(15'h7FFF, 2'b11);
    idle(13); apply(15'h3FFF, 2'b11);
    idle(2);  apply(15'h3FFE, 2'b11);
    drain("R4 time tags");

    // R5 time load then event
    @(negedge clk); time_load = 1; time_value = 64'h0000_1234_5678_0000;
    @(negedge clk); time_load = 0;
    idle(6); apply(15'h3FFF, 2'b11);
    idle(5); apply(15'h7FFF, 2'b11);
    drain("R5 loaded time");

    // R6 order and count over a burst
    apply(15'h7FFE, 2'b11);
    apply(15'h7FFC, 2'b11);
    idle(2);
    apply(15'h7FF8, 2'b11);
    @(negedge clk);
    chk(rd_count == 3 && rd_valid, "R6 count", rd_count, 3);
    drain("R6 order");

    // R7 overflow on wrap
    for (int i = 0; i < 10; i++) apply(permit_in ^ 15'h0001, 2'b11);
    @(negedge clk);
    chk(rd_count == D, "R7 count saturates", rd_count, D);
    chk(overflow == exp_ovf && overflow, "R7 overflow set", overflow, 1);
    drain("R7 newest kept");
    chk(overflow == 1, "R7 overflow sticky", overflow, 1);
    do_rearm();
    chk(overflow == 0, "R9 overflow cleared", overflow, 0);

    // R8 freeze after first fall, refall does not restart
    freeze_post = 8'd2;
    do_rearm();
    apply(15'h7FFF, 2'b10);
    apply(15'h7FFF, 2'b11);
    apply(15'h7FFF, 2'b01);
    apply(15'h7FF0, 2'b01);
    apply(15'h7F00, 2'b01);
    @(negedge clk);
    chk(frozen == 1, "R8 frozen", frozen, 1);
    chk(rd_count == 3, "R8 count after freeze", rd_count, 3);
    drain("R8 window records");

    // R9 rearm resumes
    do_rearm();
    chk(frozen == 0, "R9 frozen cleared", frozen, 0);
    apply(15'h7FFF, 2'b11);
    @(negedge clk);
    chk(rd_count == 1, "R9 logging resumed", rd_count, 1);
    drain("R9 record");

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule